// File: doc/BRIEF.md
# Windowed Register File Mapper

This block is the integer register file of a RISC core whose registers are arranged in overlapping windows. An instruction names one of 32 architectural registers with a 5-bit number. Together with the current window pointer, that number is turned into a physical location. Names 0 to 7 select a small bank of globals that every window shares. Names 8 to 31 select a circular bank with sixteen physical registers per window.

Within each window, names 8 to 15 are the outgoing registers, 16 to 23 are the private locals and 24 to 31 are the incoming registers. Neighbouring windows overlap. The incoming registers of the window at pointer `c` are the same storage as the outgoing registers of the window at pointer `c+1`. The last window wraps around onto window 0.

The file has two combinational read ports and one write port that takes effect on the clock edge. The window pointer and the number of windows in use are inputs. The storage is sized for the largest window count, which is set by a parameter.

Top module: `winreg_file`

## Requirements
- R1: Names 1 to 7 select a shared eight-entry global bank, and that bank does not depend on `cwp_i`. A value written at one window pointer reads back unchanged at any other pointer.
- R2: Name 0 always reads as zero on both ports, and a write to name 0 changes nothing.
- R3: A windowed name `r` (8 to 31) selects physical slot `(c*16 + r - 8) mod (n*16)`, where `c` is the effective pointer and `n` is `nwin_i`. The groups are: outs 8–15, locals 16–23, ins 24–31.
- R4: A write to out name `8+k` at pointer `c` is visible through in name `24+k` at pointer `c-1`. This includes the wrap, where the outs of window 0 are the ins of window `n-1`.
- R5: The locals (16–23) of different windows use separate storage. A write to a local at one pointer leaves the locals of every other pointer unchanged.
- R6: The effective window pointer is `cwp_i mod nwin_i`. Pointers `c` and `c+n` therefore reach the same registers.
- R7: A write lands on the rising clock edge. A read of the same register in the same cycle returns the old value, and the new value is visible from the next cycle. The two read ports act independently.
- R8: When `nwin_i` is below 2 or above the `NWIN` parameter, the write port is ignored and both read ports return zero.
- R9: While `rst_n` is low, every global and windowed register is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset that clears all storage |
| cwp_i | input | 5 | Current window pointer, taken modulo `nwin_i` |
| nwin_i | input | 6 | Number of windows in use; valid from 2 to `NWIN` |
| ra0_i | input | 5 | Read port 0 register name |
| ra1_i | input | 5 | Read port 1 register name |
| rd0_o | output | DATA_W | Read port 0 data |
| rd1_o | output | DATA_W | Read port 1 data |
| we_i | input | 1 | Write enable |
| wa_i | input | 5 | Write register name |
| wd_i | input | DATA_W | Write data |

## Verification
The bench attacks the overlap between adjacent windows. It writes outs and then reads them as the ins one pointer lower. A mapper with the wrong sign would show the value one window the wrong way, or not at all. The wrap from window 0 to the last window is tested both at the full window count and at a smaller, non-power-of-two count. A mapper that wraps at the storage size rather than at `nwin_i*16` would leave the last window's ins reading stale data. Further checks cover locals leaking between windows, pointers at or above the window count, same-cycle read-after-write, and invalid window counts. Each of these would appear as a mismatch against the bench's reference model.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
   localparam int unsigned NAME_W   = 5;
   localparam int unsigned CWP_W    = 5;
   localparam int unsigned NWIN_W   = 6;
   localparam int unsigned SLOTS_PER_WIN = 16;
   localparam int unsigned GLOBALS  = 8;
   localparam int unsigned MAX_WIN  = 32;
   localparam int unsigned MIN_WIN  = 2;

   typedef struct packed {
      logic valid;
      logic global_sel;
   } map_kind_t;
endpackage

// File: rtl/winreg_map.sv
module winreg_map
   import winreg_pkg::*;
#(
   parameter int unsigned NWIN  = 8,
   parameter int unsigned IDX_W = 7
) (
   input  logic [NAME_W-1:0] name_i,
   input  logic [CWP_W-1:0]  cwp_i,
   input  logic [NWIN_W-1:0] nwin_i,
   output map_kind_t         kind_o,
   output logic [2:0]        gidx_o,
   output logic [IDX_W-1:0]  widx_o
);
   localparam int unsigned SUM_W     = IDX_W + 1;
   localparam int unsigned MOD_STEPS = (1 << CWP_W) / MIN_WIN;

   logic [NWIN_W-1:0] eff_cwp;
   logic [SUM_W-1:0]  base;
   logic [SUM_W-1:0]  span;
   logic [SUM_W-1:0]  sum;

   always_comb begin
      kind_o.valid      = (nwin_i >= NWIN_W'(MIN_WIN)) && (nwin_i <= NWIN_W'(NWIN));
      kind_o.global_sel = (name_i < NAME_W'(GLOBALS));
      gidx_o            = name_i[2:0];

      eff_cwp = {1'b0, cwp_i};
      for (int s = 0; s < MOD_STEPS; s++) begin
         if (kind_o.valid && (eff_cwp >= nwin_i)) eff_cwp = eff_cwp - nwin_i;
      end

      base = SUM_W'(eff_cwp) * SUM_W'(SLOTS_PER_WIN);
      span = SUM_W'(nwin_i) * SUM_W'(SLOTS_PER_WIN);
      sum  = base + SUM_W'(name_i - NAME_W'(GLOBALS));
      if (sum >= span) sum = sum - span;
      widx_o = sum[IDX_W-1:0];
   end
endmodule

// File: rtl/winreg_bank.sv
module winreg_bank #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned DEPTH      = 128,
   parameter int unsigned AW         = 7,
   parameter bit          ZERO_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [AW-1:0]     wa_i,
   input  logic [DATA_W-1:0] wd_i,
   input  logic [AW-1:0]     ra0_i,
   input  logic [AW-1:0]     ra1_i,
   output logic [DATA_W-1:0] rd0_o,
   output logic [DATA_W-1:0] rd1_o
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic              wr_ok;

   generate
      if (ZERO_FIRST) begin : g_hard_zero
         assign wr_ok = we_i && (wa_i != '0);
         assign rd0_o = (ra0_i == '0) ? '0 : mem[ra0_i];
         assign rd1_o = (ra1_i == '0) ? '0 : mem[ra1_i];
      end else begin : g_plain
         assign wr_ok = we_i;
         assign rd0_o = mem[ra0_i];
         assign rd1_o = mem[ra1_i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
      end else if (wr_ok) begin
         mem[wa_i] <= wd_i;
      end
   end
endmodule

// File: rtl/winreg_file.sv
module winreg_file
   import winreg_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NWIN   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        cwp_i,
   input  logic [5:0]        nwin_i,
   input  logic [4:0]        ra0_i,
   input  logic [4:0]        ra1_i,
   output logic [DATA_W-1:0] rd0_o,
   output logic [DATA_W-1:0] rd1_o,
   input  logic              we_i,
   input  logic [4:0]        wa_i,
   input  logic [DATA_W-1:0] wd_i
);
   localparam int unsigned WDEPTH = NWIN * SLOTS_PER_WIN;
   localparam int unsigned IDX_W  = $clog2(WDEPTH);
   localparam int unsigned NPORTS = 3;

   initial begin
      assert (NWIN >= MIN_WIN && NWIN <= MAX_WIN)
         else $error("winreg_file: NWIN must lie in 2..32");
      assert (DATA_W >= 1)
         else $error("winreg_file: DATA_W must be positive");
   end

   logic [NAME_W-1:0] name   [NPORTS];
   map_kind_t         kind   [NPORTS];
   logic [2:0]        gidx   [NPORTS];
   logic [IDX_W-1:0]  widx   [NPORTS];

   assign name[0] = ra0_i;
   assign name[1] = ra1_i;
   assign name[2] = wa_i;

   generate
      for (genvar p = 0; p < NPORTS; p++) begin : g_map
         winreg_map #(.NWIN(NWIN), .IDX_W(IDX_W)) u_map (
            .name_i (name[p]),
            .cwp_i  (cwp_i),
            .nwin_i (nwin_i),
            .kind_o (kind[p]),
            .gidx_o (gidx[p]),
            .widx_o (widx[p])
         );
      end
   endgenerate

   logic              g_we, w_we;
   logic [DATA_W-1:0] g_rd0, g_rd1, w_rd0, w_rd1;

   assign g_we = we_i && kind[2].valid &&  kind[2].global_sel;
   assign w_we = we_i && kind[2].valid && !kind[2].global_sel;

   winreg_bank #(.DATA_W(DATA_W), .DEPTH(GLOBALS), .AW(3), .ZERO_FIRST(1'b1)) u_globals (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (g_we),
      .wa_i  (gidx[2]),
      .wd_i  (wd_i),
      .ra0_i (gidx[0]),
      .ra1_i (gidx[1]),
      .rd0_o (g_rd0),
      .rd1_o (g_rd1)
   );

   winreg_bank #(.DATA_W(DATA_W), .DEPTH(WDEPTH), .AW(IDX_W), .ZERO_FIRST(1'b0)) u_windows (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (w_we),
      .wa_i  (widx[2]),
      .wd_i  (wd_i),
      .ra0_i (widx[0]),
      .ra1_i (widx[1]),
      .rd0_o (w_rd0),
      .rd1_o (w_rd1)
   );

   always_comb begin
      rd0_o = '0;
      rd1_o = '0;
      if (kind[0].valid) rd0_o = kind[0].global_sel ? g_rd0 : w_rd0;
      if (kind[1].valid) rd1_o = kind[1].global_sel ? g_rd1 : w_rd1;
   end
endmodule

// File: rtl/winreg_chk.sv
module winreg_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NWIN   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        cwp_i,
   input logic [5:0]        nwin_i,
   input logic [4:0]        ra0_i,
   input logic [4:0]        ra1_i,
   input logic [DATA_W-1:0] rd0_o,
   input logic [DATA_W-1:0] rd1_o,
   input logic              we_i,
   input logic [4:0]        wa_i,
   input logic [DATA_W-1:0] wd_i
);
   function automatic int unsigned wrap_ptr(input int unsigned c, input int unsigned n);
      return (n == 0) ? c : (c % n);
   endfunction

   logic nw_ok;
   assign nw_ok = (nwin_i >= 6'd2) && (nwin_i <= 6'(NWIN));

   // R2: name 0 reads zero on both ports
   assert_r0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((ra0_i == 5'd0) |-> (rd0_o == '0)) and ((ra1_i == 5'd0) |-> (rd1_o == '0)));

   // R8: an invalid window count forces zero reads
   assert_bad_nwin_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !nw_ok |-> (rd0_o == '0 && rd1_o == '0));

   // R7: a write becomes visible on the next cycle at the same name and pointer
   assert_write_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && nw_ok && wa_i != 5'd0) |=>
         ((ra0_i == $past(wa_i) && cwp_i == $past(cwp_i) && nwin_i == $past(nwin_i))
            -> (rd0_o == $past(wd_i))));

   // R7: without a write and with steady inputs the read data holds
   assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_i ##1 ($stable(ra0_i) && $stable(cwp_i) && $stable(nwin_i))) |-> $stable(rd0_o));

   // R4: an out written at pointer c shows as the matching in at pointer c-1
   assert_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && nw_ok && wa_i >= 5'd8 && wa_i <= 5'd15) |=>
         ((nwin_i == $past(nwin_i) && ra0_i == $past(wa_i) + 5'd16 &&
           wrap_ptr(int'(cwp_i) + 1, int'(nwin_i)) == wrap_ptr(int'($past(cwp_i)), int'(nwin_i)))
            -> (rd0_o == $past(wd_i))));
endmodule

bind winreg_file winreg_chk #(.DATA_W(DATA_W), .NWIN(NWIN)) u_chk (
   .clk(clk), .rst_n(rst_n), .cwp_i(cwp_i), .nwin_i(nwin_i),
   .ra0_i(ra0_i), .ra1_i(ra1_i), .rd0_o(rd0_o), .rd1_o(rd1_o),
   .we_i(we_i), .wa_i(wa_i), .wd_i(wd_i)
);

// File: tb/winreg_file_test.sv
module winreg_file_test;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned NWIN   = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [4:0]        cwp_i = '0;
   logic [5:0]        nwin_i = 6'(NWIN);
   logic [4:0]        ra0_i = '0, ra1_i = '0, wa_i = '0;
   logic              we_i = 1'b0;
   logic [DATA_W-1:0] wd_i = '0;
   logic [DATA_W-1:0] rd0_o, rd1_o;

   int checks = 0;
   int errors = 0;
   logic [DATA_W-1:0] m_g [8];
   logic [DATA_W-1:0] m_w [NWIN*16];

   always #2 clk = ~clk;

   winreg_file #(.DATA_W(DATA_W), .NWIN(NWIN)) uut (
      .clk(clk), .rst_n(rst_n), .cwp_i(cwp_i), .nwin_i(nwin_i),
      .ra0_i(ra0_i), .ra1_i(ra1_i), .rd0_o(rd0_o), .rd1_o(rd1_o),
      .we_i(we_i), .wa_i(wa_i), .wd_i(wd_i)
   );

   function automatic bit nw_valid(input int n);
      return n >= 2 && n <= NWIN;
   endfunction

   function automatic int slot(input int r, input int c, input int n);
      return ((c % n) * 16 + r - 8) % (n * 16);
   endfunction

   function automatic logic [DATA_W-1:0] model_rd(input int r, input int c, input int n);
      if (!nw_valid(n) || r == 0) return '0;
      if (r < 8) return m_g[r];
      return m_w[slot(r, c, n)];
   endfunction

   task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // One cycle: drive at the falling edge, compare reads before the rising edge, then update the model.
   task automatic step(input int c, input int n, input int a0, input int a1,
                       input bit we, input int wa, input logic [DATA_W-1:0] wd, input string req);
      @(negedge clk);
      cwp_i = 5'(c); nwin_i = 6'(n); ra0_i = 5'(a0); ra1_i = 5'(a1);
      we_i = we; wa_i = 5'(wa); wd_i = wd;
      #1;
      check(rd0_o, model_rd(a0, c, n), req);
      check(rd1_o, model_rd(a1, c, n), req);
      @(posedge clk);
      if (we && nw_valid(n) && wa != 0) begin
         if (wa < 8) m_g[wa] = wd;
         else m_w[slot(wa, c, n)] = wd;
      end
   endtask

   task automatic wr(input int c, input int n, input int wa, input logic [DATA_W-1:0] wd, input string req);
      step(c, n, 0, wa, 1'b1, wa, wd, req);
   endtask

   task automatic rd(input int c, input int n, input int a0, input int a1, input string req);
      step(c, n, a0, a1, 1'b0, 0, '0, req);
   endtask

   initial begin : watchdog
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED_0042));
      foreach (m_g[i]) m_g[i] = '0;
      foreach (m_w[i]) m_w[i] = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R9: after reset everything reads zero
      for (int c = 0; c < NWIN; c++) rd(c, NWIN, 8 + c, 31 - c, "R9");
      rd(0, NWIN, 1, 7, "R9");

      // R2: name 0 stays zero after a write
      wr(3, NWIN, 0, 32'hDEAD_BEEF, "R2");
      rd(3, NWIN, 0, 0, "R2");

      // R1: a global written at one pointer reads the same at another
      wr(1, NWIN, 5, 32'h1111_0005, "R1");
      rd(6, NWIN, 5, 5, "R1");
      check(rd0_o, 32'h1111_0005, "R1");

      // R7: same-cycle read returns the old value, next cycle the new one
      step(2, NWIN, 17, 17, 1'b1, 17, 32'hAAAA_0017, "R7");
      rd(2, NWIN, 17, 9, "R7");
      check(rd0_o, 32'hAAAA_0017, "R7");

      // R4: outs of pointer 4 are ins of pointer 3
      wr(4, NWIN, 10, 32'h0404_000A, "R4");
      rd(3, NWIN, 26, 10, "R4");
      check(rd0_o, 32'h0404_000A, "R4");

      // R4: wrap, outs of window 0 are ins of the last window
      wr(0, NWIN, 8, 32'h0000_0808, "R4");
      rd(NWIN - 1, NWIN, 24, 8, "R4");
      check(rd0_o, 32'h0000_0808, "R4");

      // R4 and R3: wrap with a non-power-of-two count of 5
      wr(0, 5, 15, 32'h5555_000F, "R3");
      rd(4, 5, 31, 15, "R4");
      check(rd0_o, 32'h5555_000F, "R4");

      // R5: locals of one window are private
      wr(5, NWIN, 20, 32'h5050_0020, "R5");
      rd(6, NWIN, 20, 20, "R5");
      check(rd0_o, '0, "R5");
      rd(4, NWIN, 20, 20, "R5");

      // R6: pointers c and c+n share registers
      wr(1, NWIN, 22, 32'h6666_0022, "R6");
      rd(1 + NWIN, NWIN, 22, 22, "R6");
      check(rd1_o, 32'h6666_0022, "R6");
      rd(31, 5, 12, 28, "R6");

      // R8: invalid window counts ignore writes and read zero
      wr(2, 1, 11, 32'hBAD0_0001, "R8");
      wr(2, NWIN + 1, 11, 32'hBAD0_0002, "R8");
      rd(2, 0, 11, 5, "R8");
      rd(2, NWIN, 11, 11, "R8");
      check(rd0_o, '0, "R8");

      // Random traffic over valid and invalid counts (R3, R7)
      for (int t = 0; t < 3000; t++) begin
         int n;
         int sel;
         sel = int'($urandom_range(9, 0));
         n = (sel < 5) ? NWIN : (sel < 8) ? 5 : (sel == 8) ? 2 : int'($urandom_range(63, 0));
         step(int'($urandom_range(31, 0)), n, int'($urandom_range(31, 0)),
              int'($urandom_range(31, 0)), ($urandom_range(1, 0) == 1),
              int'($urandom_range(31, 0)), $urandom(), "R3");
      end

      // R9: reset again clears storage
      @(negedge clk); rst_n = 1'b0; we_i = 1'b0;
      @(posedge clk); @(negedge clk); rst_n = 1'b1;
      foreach (m_g[i]) m_g[i] = '0;
      foreach (m_w[i]) m_w[i] = '0;
      rd(4, NWIN, 10, 5, "R9");
      check(rd0_o, '0, "R9");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule